// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Master

This block performs single 16-bit word reads and writes on an external three-wire serial EEPROM. It owns the chip-select, serial-clock and serial-data-to-device pins and samples the serial-data-from-device pin. A host presents a request (direction, byte offset, write word) for one cycle. The block raises `busy`, runs the pin-level frames, and ends with a one-cycle `done`. On a read, `rdata` holds the fetched word while `done` is high.

Every write is bracketed by its own frames. A write-enable command goes first. The data write follows, then a fixed programming wait, then a write-disable command. All pin timing comes from a system-clock-frequency parameter, so no clock phase on the serial clock is shorter than one microsecond. The serial clock pin is shared with another function. That user sees `pin_busy` for the whole transaction and gets a one-cycle `pin_restore` strobe when the pin is handed back.

Top module: `serial_rom_master`

## Requirements
- R1: After reset, `rom_cs`, `rom_sk`, `rom_di`, `busy`, `done`, `pin_busy` and `pin_restore` are all low.
- R2: A request with `req_valid` high while `busy` is low is accepted. `busy` is high from the next cycle until the cycle in which `done` pulses for exactly one cycle. A request made while `busy` is high is ignored: it produces no `done` and no pin activity.
- R3: Every frame begins by raising `rom_cs` while `rom_sk` and `rom_di` are low. When `dummy_en` was high at acceptance, one clock pulse with `rom_di` low precedes the first command bit.
- R4: A read frame sends the 3-bit read opcode (default 110) and then the word address `req_offset >> 1` in `ADDR_W` bits, both MSB first. It then clocks in 16 bits, sampling `rom_do` after each full high-then-low clock period and assembling them MSB first. The word appears on `rdata` during `done`.
- R5: A write issues, in this order: a write-enable frame (5-bit prefix, default 10011, then six zero bits), a write frame (3-bit opcode, default 101, then the address, then the 16 data bits MSB first), a wait of at least `PROG_WAIT_US` microseconds, and a write-disable frame (5-bit prefix, default 10000, then six zero bits).
- R6: Each frame ends with `rom_cs` and `rom_di` driven low, followed by exactly one further clock pulse before the next frame starts.
- R7: Each high phase and each low phase of `rom_sk` lasts at least `ceil(CLK_HZ / 1e6)` system clock cycles.
- R8: `rom_di` returns low after the last bit of every shifted-out field. It stays low while `rom_cs` is low and while data is being clocked in.
- R9: `pin_busy` is high for the whole transaction, including every frame and the programming wait. When `pin_busy` falls, `pin_restore` pulses for one cycle, together with `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W+1 | Byte offset; bit 0 is dropped |
| req_wdata | input | 16 | Word to write |
| dummy_en | input | 1 | Issue a leading dummy clock pulse in each frame |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result, valid with done |
| rom_cs | output | 1 | Chip select to the device |
| rom_sk | output | 1 | Serial clock to the device |
| rom_di | output | 1 | Serial data to the device |
| rom_do | input | 1 | Serial data from the device |
| pin_busy | output | 1 | Shared clock pin is in use |
| pin_restore | output | 1 | One-cycle strobe when the pin is released |

## Verification
The bench runs a behavioural device that decodes frames only after a start bit. It therefore sees any dummy pulse that carries a high data bit, or an opcode or address shifted LSB first, as a wrong frame or a wrong word. It stores a write only when a prior enable frame was seen. It also timestamps the gap before the disable frame, so a design that skips the enable, reorders the frames or shortens the programming wait leaves an unwritten word or a protocol error. Reads at both ends of the address range and at an odd byte offset catch a wrong shift of the offset. Separate pin monitors count short clock phases, a missing or doubled cleanup pulse, a data-in line left high, and a chip select seen while the shared pin is not flagged busy. A request pulsed in the middle of a write must leave the target word untouched and add no extra completion.

// File: rtl/srom_pkg.sv
package srom_pkg;

    localparam int unsigned WORD_W       = 16;
    localparam int unsigned CMD_PAD_BITS = 6;   // zero bits after enable/disable prefix
    localparam int unsigned PREFIX_BITS  = 5;
    localparam int unsigned OPCODE_BITS  = 3;

    typedef logic [WORD_W-1:0] word_t;

    // Pin-level job handed from the sequencer to the shifter
    typedef enum logic [2:0] {
        JOB_SELECT,
        JOB_PULSE,
        JOB_SEND,
        JOB_RECV,
        JOB_RELEASE
    } job_e;

    typedef struct packed {
        job_e        kind;
        logic [4:0]  nbits;
        word_t       payload;   // left-aligned: bit WORD_W-1 goes out first
    } job_t;

    typedef enum logic [1:0] {
        FR_ENABLE,
        FR_WRITE,
        FR_DISABLE,
        FR_READ
    } frame_e;

    typedef enum logic [2:0] {
        ST_SELECT,
        ST_DUMMY,
        ST_OPCODE,
        ST_ARG,
        ST_DATA,
        ST_RELEASE
    } step_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_HIGH,
        PH_LOW
    } phase_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT_JOB,
        SQ_PROGRAM
    } seq_e;

    // System cycles in one microsecond, rounded up
    function automatic int unsigned us_cycles(int unsigned hz);
        int unsigned c;
        c = (hz + 999_999) / 1_000_000;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic word_t left_align(word_t v, int unsigned n);
        return v << (WORD_W - n);
    endfunction

    // Step order inside one frame; ST_RELEASE is the last step
    function automatic step_e step_after(frame_e fr, step_e st, logic dummy);
        step_e nx;
        unique case (st)
            ST_SELECT: nx = dummy ? ST_DUMMY : ST_OPCODE;
            ST_DUMMY:  nx = ST_OPCODE;
            ST_OPCODE: nx = ST_ARG;
            ST_ARG:    nx = (fr == FR_READ || fr == FR_WRITE) ? ST_DATA : ST_RELEASE;
            default:   nx = ST_RELEASE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/srom_tick.sv
module srom_tick #(
    parameter int unsigned HALF_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = run && (cnt_q == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/srom_shifter.sv
module srom_shifter
    import srom_pkg::*;
#(
    parameter int unsigned HALF_CYC = 200
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  job_t  job,
    input  logic  rx_bit,
    output logic  job_done,
    output word_t rx_word,
    output logic  cs,
    output logic  sk,
    output logic  di
);
    phase_e     ph_q;
    job_e       kind_q;
    logic [4:0] left_q;
    word_t      sh_q;
    logic       cs_q, sk_q, di_q, done_q;
    logic       tick;

    srom_tick #(.HALF_CYC(HALF_CYC)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (ph_q != PH_IDLE),
        .tick (tick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            kind_q <= JOB_SELECT;
            left_q <= '0;
            sh_q   <= '0;
            cs_q   <= 1'b0;
            sk_q   <= 1'b0;
            di_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ph_q)
                PH_IDLE: begin
                    if (start) begin
                        kind_q <= job.kind;
                        left_q <= job.nbits;
                        sh_q   <= job.payload;
                        unique case (job.kind)
                            JOB_SELECT: begin
                                cs_q <= 1'b1;
                                sk_q <= 1'b0;
                                di_q <= 1'b0;
                                ph_q <= PH_SETUP;
                            end
                            JOB_SEND: begin
                                sk_q <= 1'b0;
                                di_q <= job.payload[WORD_W-1];
                                ph_q <= PH_SETUP;
                            end
                            JOB_RELEASE: begin
                                cs_q <= 1'b0;
                                sk_q <= 1'b0;
                                di_q <= 1'b0;
                                ph_q <= PH_SETUP;
                            end
                            default: begin   // pulse or receive: start high
                                sk_q <= 1'b1;
                                di_q <= 1'b0;
                                ph_q <= PH_HIGH;
                            end
                        endcase
                    end
                end
                PH_SETUP: begin
                    if (tick) begin
                        if (kind_q == JOB_SELECT) begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            sk_q <= 1'b1;
                            ph_q <= PH_HIGH;
                        end
                    end
                end
                PH_HIGH: begin
                    if (tick) begin
                        sk_q <= 1'b0;
                        if (kind_q == JOB_SEND && left_q > 5'd1) begin
                            di_q   <= sh_q[WORD_W-2];
                            sh_q   <= sh_q << 1;
                            left_q <= left_q - 5'd1;
                            ph_q   <= PH_SETUP;
                        end else begin
                            di_q <= 1'b0;
                            ph_q <= PH_LOW;
                        end
                    end
                end
                PH_LOW: begin
                    if (tick) begin
                        if (kind_q == JOB_RECV) begin
                            sh_q   <= {sh_q[WORD_W-2:0], rx_bit};
                            left_q <= left_q - 5'd1;
                            if (left_q == 5'd1) begin
                                ph_q   <= PH_IDLE;
                                done_q <= 1'b1;
                            end else begin
                                sk_q <= 1'b1;
                                ph_q <= PH_HIGH;
                            end
                        end else begin
                            ph_q   <= PH_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                default: ph_q <= PH_IDLE;
            endcase
        end
    end

    assign job_done = done_q;
    assign rx_word  = sh_q;
    assign cs       = cs_q;
    assign sk       = sk_q;
    assign di       = di_q;

    // Phase-length monitor for the serial clock
    localparam int unsigned HW = $clog2(HALF_CYC + 1) + 1;
    logic [HW-1:0] hold_q;
    logic          sk_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q    <= HW'(HALF_CYC);
            sk_prev_q <= 1'b0;
        end else begin
            sk_prev_q <= sk_q;
            if (sk_q != sk_prev_q) begin
                hold_q <= HW'(1);
            end else if (hold_q < HW'(HALF_CYC)) begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end

    p_sk_phase_len_r7: assert property (@(posedge clk) disable iff (rst)
        (sk_q != sk_prev_q) |-> (hold_q >= HW'(HALF_CYC)));

    p_di_low_deselected_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_q |-> !di_q);

    p_start_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start |-> (ph_q == PH_IDLE));
endmodule

// File: rtl/srom_seq.sv
module srom_seq
    import srom_pkg::*;
#(
    parameter int unsigned ADDR_W   = 6,
    parameter int unsigned WAIT_CYC = 2_000_000,
    parameter logic [2:0]  RD_OP    = 3'b110,
    parameter logic [2:0]  WR_OP    = 3'b101,
    parameter logic [4:0]  EN_OP    = 5'b10011,
    parameter logic [4:0]  DIS_OP   = 5'b10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_word,
    input  word_t             req_wdata,
    input  logic              dummy_en,
    input  logic              job_done,
    input  word_t             rx_word,
    output logic              job_start,
    output job_t              job,
    output logic              busy,
    output logic              done,
    output word_t             rdata,
    output logic              pin_restore
);
    localparam int unsigned WCW = $clog2(WAIT_CYC + 1);

    seq_e              state_q;
    frame_e            frame_q;
    step_e             step_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             wdata_q;
    logic              dummy_q;
    logic [WCW-1:0]    wait_q;
    word_t             rdata_q;
    logic              done_q;
    logic              restore_q;

    // Job contents for the current step
    always_comb begin
        job.kind    = JOB_RELEASE;
        job.nbits   = 5'd0;
        job.payload = '0;
        unique case (step_q)
            ST_SELECT: job.kind = JOB_SELECT;
            ST_DUMMY:  job.kind = JOB_PULSE;
            ST_OPCODE: begin
                job.kind = JOB_SEND;
                unique case (frame_q)
                    FR_ENABLE: begin
                        job.nbits   = 5'(PREFIX_BITS);
                        job.payload = left_align(word_t'(EN_OP), PREFIX_BITS);
                    end
                    FR_DISABLE: begin
                        job.nbits   = 5'(PREFIX_BITS);
                        job.payload = left_align(word_t'(DIS_OP), PREFIX_BITS);
                    end
                    FR_WRITE: begin
                        job.nbits   = 5'(OPCODE_BITS);
                        job.payload = left_align(word_t'(WR_OP), OPCODE_BITS);
                    end
                    default: begin
                        job.nbits   = 5'(OPCODE_BITS);
                        job.payload = left_align(word_t'(RD_OP), OPCODE_BITS);
                    end
                endcase
            end
            ST_ARG: begin
                job.kind = JOB_SEND;
                if (frame_q == FR_ENABLE || frame_q == FR_DISABLE) begin
                    job.nbits   = 5'(CMD_PAD_BITS);
                    job.payload = '0;
                end else begin
                    job.nbits   = 5'(ADDR_W);
                    job.payload = left_align(word_t'(addr_q), ADDR_W);
                end
            end
            ST_DATA: begin
                job.nbits = 5'(WORD_W);
                if (frame_q == FR_READ) begin
                    job.kind    = JOB_RECV;
                    job.payload = '0;
                end else begin
                    job.kind    = JOB_SEND;
                    job.payload = wdata_q;
                end
            end
            default: job.kind = JOB_RELEASE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SQ_IDLE;
            frame_q   <= FR_READ;
            step_q    <= ST_SELECT;
            addr_q    <= '0;
            wdata_q   <= '0;
            dummy_q   <= 1'b0;
            wait_q    <= '0;
            rdata_q   <= '0;
            done_q    <= 1'b0;
            restore_q <= 1'b0;
        end else begin
            done_q    <= 1'b0;
            restore_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_word;
                        wdata_q <= req_wdata;
                        dummy_q <= dummy_en;
                        frame_q <= req_write ? FR_ENABLE : FR_READ;
                        step_q  <= ST_SELECT;
                        state_q <= SQ_ISSUE;
                    end
                end
                SQ_ISSUE: state_q <= SQ_WAIT_JOB;
                SQ_WAIT_JOB: begin
                    if (job_done) begin
                        if (step_q == ST_DATA && frame_q == FR_READ) begin
                            rdata_q <= rx_word;
                        end
                        if (step_q != ST_RELEASE) begin
                            step_q  <= step_after(frame_q, step_q, dummy_q);
                            state_q <= SQ_ISSUE;
                        end else begin
                            unique case (frame_q)
                                FR_ENABLE: begin
                                    frame_q <= FR_WRITE;
                                    step_q  <= ST_SELECT;
                                    state_q <= SQ_ISSUE;
                                end
                                FR_WRITE: begin
                                    wait_q  <= '0;
                                    state_q <= SQ_PROGRAM;
                                end
                                default: begin
                                    done_q    <= 1'b1;
                                    restore_q <= 1'b1;
                                    state_q   <= SQ_IDLE;
                                end
                            endcase
                        end
                    end
                end
                SQ_PROGRAM: begin
                    if (wait_q >= WCW'(WAIT_CYC - 1)) begin
                        frame_q <= FR_DISABLE;
                        step_q  <= ST_SELECT;
                        state_q <= SQ_ISSUE;
                    end else begin
                        wait_q <= wait_q + 1'b1;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign job_start   = (state_q == SQ_ISSUE);
    assign busy        = (state_q != SQ_IDLE);
    assign done        = done_q;
    assign rdata       = rdata_q;
    assign pin_restore = restore_q;

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    p_accept_sets_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);

    p_done_ends_busy_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_q);

    p_program_follows_write_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_PROGRAM) |-> (frame_q == FR_WRITE));
endmodule

// File: rtl/serial_rom_master.sv
module serial_rom_master
    import srom_pkg::*;
#(
    parameter int unsigned CLK_HZ       = 200_000_000,
    parameter int unsigned PROG_WAIT_US = 10_000,
    parameter int unsigned ADDR_W       = 6,
    parameter logic [2:0]  RD_OP        = 3'b110,
    parameter logic [2:0]  WR_OP        = 3'b101,
    parameter logic [4:0]  EN_OP        = 5'b10011,
    parameter logic [4:0]  DIS_OP       = 5'b10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W:0]   req_offset,
    input  logic [15:0]       req_wdata,
    input  logic              dummy_en,
    output logic              busy,
    output logic              done,
    output logic [15:0]       rdata,
    output logic              rom_cs,
    output logic              rom_sk,
    output logic              rom_di,
    input  logic              rom_do,
    output logic              pin_busy,
    output logic              pin_restore
);
    localparam int unsigned HALF_CYC = us_cycles(CLK_HZ);
    localparam int unsigned WAIT_CYC = HALF_CYC * PROG_WAIT_US;

    logic  job_start, job_done;
    job_t  job;
    word_t rx_word;
    logic  do_meta_q, do_sync_q;
    logic  unused_offset_lsb;

    assign unused_offset_lsb = req_offset[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            do_meta_q <= 1'b0;
            do_sync_q <= 1'b0;
        end else begin
            do_meta_q <= rom_do;
            do_sync_q <= do_meta_q;
        end
    end

    srom_seq #(
        .ADDR_W   (ADDR_W),
        .WAIT_CYC (WAIT_CYC),
        .RD_OP    (RD_OP),
        .WR_OP    (WR_OP),
        .EN_OP    (EN_OP),
        .DIS_OP   (DIS_OP)
    ) u_seq (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_word    (req_offset[ADDR_W:1]),
        .req_wdata   (req_wdata),
        .dummy_en    (dummy_en),
        .job_done    (job_done),
        .rx_word     (rx_word),
        .job_start   (job_start),
        .job         (job),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .pin_restore (pin_restore)
    );

    srom_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .start    (job_start),
        .job      (job),
        .rx_bit   (do_sync_q),
        .job_done (job_done),
        .rx_word  (rx_word),
        .cs       (rom_cs),
        .sk       (rom_sk),
        .di       (rom_di)
    );

    assign pin_busy = busy;

    p_cs_needs_pin_busy_r9: assert property (@(posedge clk) disable iff (rst)
        rom_cs |-> pin_busy);

    p_restore_on_release_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_busy) |-> pin_restore);
endmodule

// File: tb/serial_rom_master_tb.sv
module serial_rom_master_tb;
    localparam int unsigned AW    = 6;
    localparam int unsigned HALF  = 4;     // 4 MHz setting -> 4 cycles per microsecond
    localparam int unsigned WAITC = 200;   // 50 us programming wait

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, dummy_en = 1'b0;
    logic [AW:0] req_offset = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done, rom_cs, rom_sk, rom_di, pin_busy, pin_restore;
    logic        rom_do = 1'b0;
    logic [15:0] rdata;

    always #2.5 clk = ~clk;

    serial_rom_master #(
        .CLK_HZ       (4_000_000),
        .PROG_WAIT_US (50),
        .ADDR_W       (AW)
    ) u_dut (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_write (req_write),
        .req_offset (req_offset), .req_wdata (req_wdata), .dummy_en (dummy_en),
        .busy (busy), .done (done), .rdata (rdata), .rom_cs (rom_cs),
        .rom_sk (rom_sk), .rom_di (rom_di), .rom_do (rom_do),
        .pin_busy (pin_busy), .pin_restore (pin_restore)
    );

    int checks = 0, errors = 0;

    task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural device ----------------
    logic [15:0] mem     [64];
    logic [15:0] ref_mem [64];
    bit          we_en = 0, started = 0, reading = 0, seen_frame = 0, prog_pend = 0;
    logic [31:0] cmd = 0;
    int          nb = 0, ridx = 0, rises = 0, cl_rises = 0;
    int          last_rises = 0;
    bit          first_di = 0, last_first_di = 0;
    logic [5:0]  raddr = 0;
    longint      cyc = 0, prog_end = 0;
    int          proto_err = 0, tim_err = 0, di_err = 0, cleanup_err = 0, start_err = 0, pin_err = 0;
    bit          sk_d = 0, cs_d = 0;
    int          sk_run = HALF;
    string       flog = "";

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            // R7 phase length
            if (rom_sk != sk_d) begin
                if (sk_run < HALF) tim_err++;
                sk_run = 1;
            end else begin
                sk_run++;
            end
            // R8 data-in low while deselected
            if (!rom_cs && rom_di) di_err++;
            // R9 pin flagged busy while selected
            if (rom_cs && !pin_busy) pin_err++;

            if (rom_cs && !cs_d) begin
                if (rom_sk || rom_di) start_err++;            // R3
                if (seen_frame && cl_rises != 1) cleanup_err++; // R6
                if (prog_pend && (cyc - prog_end) < WAITC) proto_err++; // R5
                prog_pend  = 0;
                seen_frame = 1;
                started = 0; reading = 0; nb = 0; cmd = 0; rises = 0; ridx = 0;
            end
            if (!rom_cs && rom_sk && !sk_d) cl_rises++;
            if (rom_cs && rom_sk && !sk_d) begin
                rises++;
                if (rises == 1) first_di = rom_di;
                if (reading) begin
                    if (rom_di) di_err++;
                    if (ridx < 16) rom_do <= mem[raddr][15-ridx];
                    ridx++;
                end else if (!started) begin
                    if (rom_di) begin started = 1; cmd = 1; nb = 1; end
                end else begin
                    cmd = {cmd[30:0], rom_di};
                    nb++;
                    if (nb == 3 + AW && cmd[2+AW -: 3] == 3'b110) begin
                        reading = 1;
                        raddr   = cmd[AW-1:0];
                        ridx    = 0;
                    end
                end
            end
            if (!rom_cs && cs_d) begin
                cl_rises = 0;
                last_rises = rises;
                last_first_di = first_di;
                if (reading && ridx == 16) begin
                    flog = {flog, "R"};
                end else if (nb == 3 + AW + 16 && cmd[AW+18 -: 3] == 3'b101) begin
                    if (!we_en) proto_err++;
                    else mem[cmd[AW+15:16]] = cmd[15:0];
                    flog = {flog, "W"};
                    prog_pend = 1;
                    prog_end  = cyc;
                end else if (nb == 11 && cmd[10:6] == 5'b10011 && cmd[5:0] == 0) begin
                    we_en = 1;
                    flog = {flog, "E"};
                end else if (nb == 11 && cmd[10:6] == 5'b10000 && cmd[5:0] == 0) begin
                    we_en = 0;
                    flog = {flog, "D"};
                end else begin
                    proto_err++;
                    flog = {flog, "?"};
                end
            end
            sk_d = rom_sk;
            cs_d = rom_cs;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit          is_rd;
        bit          dummy;
        logic [5:0]  word;
        logic [15:0] val;
    } exp_t;
    exp_t sbq[$];
    int   accepted = 0, dones = 0;

    always @(negedge clk) begin
        if (!rst && pin_restore && !done) check(0, "R9", "restore without done", 1, 0);
        if (!rst && done) begin
            exp_t e;
            dones++;
            check(pin_restore == 1'b1, "R9", "restore strobe with done", pin_restore, 1);
            if (sbq.size() == 0) begin
                check(0, "R2", "done with no accepted request", 1, 0);
            end else begin
                e = sbq.pop_front();
                if (e.is_rd) begin
                    check(rdata == e.val, "R4", "read word", rdata, e.val);
                    check(last_rises == int'(e.dummy) + 3 + AW + 16, "R3",
                          "clock rises in read frame", last_rises, int'(e.dummy) + 3 + AW + 16);
                    check(last_first_di == !e.dummy, "R3", "first bit clocked",
                          last_first_di, !e.dummy);
                    check(flog.len() > 0 && flog.substr(flog.len()-1, flog.len()-1) == "R",
                          "R4", "read frame decoded", 0, 1);
                end else begin
                    check(mem[e.word] == e.val, "R5", "stored word", mem[e.word], e.val);
                    check(flog.len() >= 3 && flog.substr(flog.len()-3, flog.len()-1) == "EWD",
                          "R5", "enable/write/disable order", 0, 1);
                    check(we_en == 0, "R5", "write disabled at end", we_en, 0);
                end
                check(proto_err == 0, "R5", "device protocol errors", proto_err, 0);
            end
        end
    end

    task automatic issue(bit wr, logic [AW:0] off, logic [15:0] wd, bit dm);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = off;
        req_wdata  = wd;
        dummy_en   = dm;
        e.is_rd = !wr;
        e.dummy = dm;
        e.word  = off[AW:1];
        if (wr) begin
            ref_mem[off[AW:1]] = wd;
            e.val = wd;
        end else begin
            e.val = ref_mem[off[AW:1]];
        end
        sbq.push_back(e);
        accepted++;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1 && pin_busy == 1'b1, "R2", "busy after accept",
              {busy, pin_busy}, 2'b11);
        while (busy) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200_000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            mem[i]     = 16'(i * 16'h0123) ^ 16'h5A3C;
            ref_mem[i] = mem[i];
        end
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check({rom_cs, rom_sk, rom_di} == 3'b000, "R1", "pins after reset",
              {rom_cs, rom_sk, rom_di}, 0);
        check({busy, done, pin_busy, pin_restore} == 4'b0000, "R1", "status after reset",
              {busy, done, pin_busy, pin_restore}, 0);

        // R4 reads: lowest, highest, odd offset (word 10); R3 dummy on/off
        issue(1'b0, 7'd0,   16'h0, 1'b0);
        issue(1'b0, 7'd127, 16'h0, 1'b1);
        issue(1'b0, 7'd21,  16'h0, 1'b0);

        // R5 writes with data patterns, each read back
        issue(1'b1, 7'd10,  16'hFFFF, 1'b0);
        issue(1'b0, 7'd10,  16'h0,    1'b1);
        issue(1'b1, 7'd0,   16'h0000, 1'b1);
        issue(1'b0, 7'd1,   16'h0,    1'b0);
        issue(1'b1, 7'd126, 16'hA5C3, 1'b1);
        issue(1'b0, 7'd126, 16'h0,    1'b0);

        // R2 request during busy is ignored: write word 20, poke word 33 mid-way
        fork
            issue(1'b1, 7'd40, 16'h1E2D, 1'b0);
            begin
                repeat (40) @(negedge clk);
                check(busy == 1'b1, "R2", "still busy mid-write", busy, 1);
                req_valid  = 1'b1;
                req_write  = 1'b1;
                req_offset = 7'd66;
                req_wdata  = 16'hDEAD;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        check(dones == accepted, "R2", "done count equals accepted", dones, accepted);
        check(mem[33] == ref_mem[33], "R2", "ignored write left word", mem[33], ref_mem[33]);
        issue(1'b0, 7'd66, 16'h0, 1'b0);
        issue(1'b0, 7'd40, 16'h0, 1'b1);

        repeat (4 * HALF) @(negedge clk);
        check(tim_err == 0, "R7", "short clock phases", tim_err, 0);
        check(di_err == 0, "R8", "data-in high when it must be low", di_err, 0);
        check(cleanup_err == 0 && cl_rises == 1, "R6", "cleanup pulse count",
              cleanup_err, 0);
        check(start_err == 0, "R3", "frame start with clock/data high", start_err, 0);
        check(pin_err == 0, "R9", "select while pin not busy", pin_err, 0);
        check(proto_err == 0, "R5", "protocol errors total", proto_err, 0);
        check(sbq.size() == 0, "R2", "outstanding requests", sbq.size(), 0);
        finish_run();
    end
endmodule